// File: doc/BRIEF.md
# Bit-Slice Adder/Logic ALU

This block is a purely combinational arithmetic and logic unit of configurable width. It is assembled from identical one-bit slices. Each slice holds a full adder whose B operand first passes through a controllable inverter. With that inverter the same ripple chain performs both addition and two's-complement subtraction.

In logic mode each slice reuses the propagate (XOR) and generate (AND) terms of its adder. A four-way selector picks one of four functions from those terms: constant zero, XOR, AND, or OR. A final per-bit XOR, driven by an invert control, yields the complemented functions: all-ones, XNOR, NAND and NOR. The carry into every slice is held at zero in logic mode, so nothing ripples.

The block has no clock and no registers. Operands and controls are presented together, and the result settles combinationally. There is no valid/ready handshake, because nothing is stored and nothing can stall.

Top module: `alu_bitslice`

## Requirements
- R1: With `arith_i`=1 and `sub_i`=0, the concatenation {`cout_o`,`y_o`} equals `a_i` + `b_i` + `cin_i` as an unsigned (WIDTH+1)-bit sum.
- R2: With `arith_i`=1 and `sub_i`=1, {`cout_o`,`y_o`} equals `a_i` + ~`b_i` + `cin_i`. With `cin_i`=1 this gives `y_o` = `a_i` − `b_i` modulo 2^WIDTH, and `cout_o`=1 exactly when `a_i` ≥ `b_i` unsigned.
- R3: With `arith_i`=0 and `fn_i`=2'b00, every bit of the result before inversion is 0.
- R4: With `arith_i`=0 and `fn_i`=2'b01, the result before inversion is `a_i` XOR B', where B' = `b_i` XOR {WIDTH{`sub_i`}}.
- R5: With `arith_i`=0 and `fn_i`=2'b10, the result before inversion is `a_i` AND B'.
- R6: With `arith_i`=0 and `fn_i`=2'b11, the result before inversion is `a_i` OR B'.
- R7: In logic mode, `inv_i`=1 complements every bit of the selected function. This gives all-ones, XNOR, NAND or NOR.
- R8: In logic mode `cout_o` is 0, and `cin_i` has no effect on `y_o`.
- R9: In arithmetic mode `inv_i` has no effect on `y_o` or `cout_o`.
- R10: In logic mode `sub_i`=1 inverts the B operand before the function is applied. For example, AND then gives `a_i` AND NOT `b_i`.
- R11: A carry propagates through every slice. With `a_i` all ones, `b_i`=0, `cin_i`=1 and `sub_i`=0, the outputs are `y_o`=0 and `cout_o`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B, before the optional inversion |
| arith_i | input | 1 | 1 = arithmetic mode, 0 = logic mode |
| sub_i | input | 1 | Inverts operand B in every slice |
| fn_i | input | 2 | Logic function: 00 zero, 01 XOR, 10 AND, 11 OR |
| inv_i | input | 1 | Complements the logic-mode result |
| cin_i | input | 1 | Carry into the lowest slice (arithmetic mode only) |
| y_o | output | WIDTH | Result |
| cout_o | output | 1 | Carry from the top slice; 0 in logic mode |

## Verification
The block holds no state, so any fault shows at the ports in the same evaluation as the inputs that trigger it. A broken link in the carry chain shows as a wrong high-order sum or carry-out on operands that ripple far. The all-ones-plus-one case exposes this in one vector. Failing to suppress the carry in logic mode shows as a nonzero `cout_o`, or as a `cin_i`-dependent bit 0. A mis-wired selector or inverter shows as a wrong bit pattern for the affected function code only.

// File: rtl/alu_bitslice_pkg.sv
package alu_bitslice_pkg;
  typedef enum logic [1:0] {
    FN_ZERO = 2'b00,
    FN_XOR  = 2'b01,
    FN_AND  = 2'b10,
    FN_OR   = 2'b11
  } logic_fn_e;
endpackage

// File: rtl/alu_fa_core.sv
// Full adder exposing its propagate (XOR) and generate (AND) terms.
module alu_fa_core (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic p_o,
  output logic g_o,
  output logic s_o,
  output logic c_o
);
  assign p_o = a_i ^ b_i;
  assign g_o = a_i & b_i;
  assign s_o = p_o ^ c_i;
  assign c_o = g_o | (p_o & c_i);
endmodule

// File: rtl/alu_logic_mux.sv
// Picks a logic function from the adder terms, then optionally inverts it.
module alu_logic_mux
  import alu_bitslice_pkg::*;
(
  input  logic      p_i,
  input  logic      g_i,
  input  logic_fn_e fn_i,
  input  logic      inv_i,
  output logic      y_o
);
  logic pick;
  always_comb begin
    unique case (fn_i)
      FN_ZERO: pick = 1'b0;
      FN_XOR:  pick = p_i;
      FN_AND:  pick = g_i;
      FN_OR:   pick = p_i | g_i;
      default: pick = 1'b0;
    endcase
  end
  assign y_o = pick ^ inv_i;
endmodule

// File: rtl/alu_slice.sv
// One bit of the ALU: B inverter, full adder, logic selector, carry gating.
module alu_slice
  import alu_bitslice_pkg::*;
(
  input  logic      a_i,
  input  logic      b_i,
  input  logic      sub_i,
  input  logic      arith_i,
  input  logic_fn_e fn_i,
  input  logic      inv_i,
  input  logic      cin_i,
  output logic      y_o,
  output logic      cout_o
);
  logic b_eff, c_eff, p, g, s, c_raw, lg;

  assign b_eff = b_i ^ sub_i;
  assign c_eff = cin_i & arith_i;

  alu_fa_core u_fa (
    .a_i(a_i), .b_i(b_eff), .c_i(c_eff),
    .p_o(p), .g_o(g), .s_o(s), .c_o(c_raw)
  );

  alu_logic_mux u_mux (
    .p_i(p), .g_i(g), .fn_i(fn_i), .inv_i(inv_i), .y_o(lg)
  );

  assign y_o    = arith_i ? s : lg;
  assign cout_o = arith_i & c_raw;

  always_comb begin
    // R8: no carry leaves a slice in logic mode
    if (!arith_i) a_r8_slice_no_carry: assert (cout_o == 1'b0);
  end
endmodule

// File: rtl/alu_bitslice.sv
module alu_bitslice
  import alu_bitslice_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             arith_i,
  input  logic             sub_i,
  input  logic [1:0]       fn_i,
  input  logic             inv_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] y_o,
  output logic             cout_o
);
  localparam int CW = WIDTH + 1;

  logic_fn_e        fn_e;
  logic [WIDTH:0]   chain;
  logic [WIDTH-1:0] b_op;

  assign fn_e     = logic_fn_e'(fn_i);
  assign chain[0] = cin_i;
  assign b_op     = b_i ^ {WIDTH{sub_i}};

  for (genvar gi = 0; gi < WIDTH; gi++) begin : g_slice
    alu_slice u_sl (
      .a_i(a_i[gi]), .b_i(b_i[gi]), .sub_i(sub_i), .arith_i(arith_i),
      .fn_i(fn_e), .inv_i(inv_i), .cin_i(chain[gi]),
      .y_o(y_o[gi]), .cout_o(chain[gi+1])
    );
  end

  assign cout_o = chain[WIDTH];

  always_comb begin
    if (arith_i) begin
      a_r1_r2_arith_sum: assert ({cout_o, y_o} ==
        (CW'(a_i) + CW'(b_op) + CW'(cin_i)));
    end else begin
      a_r8_no_carry_out: assert (cout_o == 1'b0);
      if (fn_i == 2'b00) a_r3_zero: assert (y_o == {WIDTH{inv_i}});
      if (fn_i == 2'b01) a_r4_xor: assert (y_o == ((a_i ^ b_op) ^ {WIDTH{inv_i}}));
      if (fn_i == 2'b10) a_r5_and: assert (y_o == ((a_i & b_op) ^ {WIDTH{inv_i}}));
      if (fn_i == 2'b11) a_r6_or: assert (y_o == ((a_i | b_op) ^ {WIDTH{inv_i}}));
    end
  end
endmodule

// File: tb/sim_alu_bitslice.sv
`timescale 1ns/1ps
module sim_alu_bitslice;
  localparam int W = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [W-1:0] a, b, y;
  logic arith, sub, inv, cin, cout;
  logic [1:0] fn;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  alu_bitslice #(.WIDTH(W)) u0 (
    .a_i(a), .b_i(b), .arith_i(arith), .sub_i(sub), .fn_i(fn),
    .inv_i(inv), .cin_i(cin), .y_o(y), .cout_o(cout)
  );

  function automatic logic [W:0] model(input logic [W-1:0] ma, input logic [W-1:0] mb,
      input logic mar, input logic msub, input logic [1:0] mfn, input logic minv,
      input logic mcin);
    logic [W-1:0] bo, r;
    bo = msub ? ~mb : mb;
    if (mar) return {1'b0, ma} + {1'b0, bo} + {{W{1'b0}}, mcin};
    case (mfn)
      2'b00: r = '0;
      2'b01: r = ma ^ bo;
      2'b10: r = ma & bo;
      default: r = ma | bo;
    endcase
    if (minv) r = ~r;
    return {1'b0, r};
  endfunction

  task automatic apply(input logic [W-1:0] ta, input logic [W-1:0] tb,
      input logic tar, input logic tsub, input logic [1:0] tfn, input logic tinv,
      input logic tcin);
    @(posedge clk);
    a = ta; b = tb; arith = tar; sub = tsub; fn = tfn; inv = tinv; cin = tcin;
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [W:0] exp);
    n_chk++;
    if ({cout, y} !== exp) begin
      n_bad++;
      $display("FAIL %s: got cout=%0b y=%h, expected cout=%0b y=%h",
               tag, cout, y, exp[W], exp[W-1:0]);
    end
  endtask

  task automatic run(input string tag, input logic [W-1:0] ta, input logic [W-1:0] tb,
      input logic tar, input logic tsub, input logic [1:0] tfn, input logic tinv,
      input logic tcin);
    apply(ta, tb, tar, tsub, tfn, tinv, tcin);
    check(tag, model(ta, tb, tar, tsub, tfn, tinv, tcin));
  endtask

  function automatic string tag_of(input logic tar, input logic tsub,
      input logic [1:0] tfn, input logic tinv);
    if (tar) return tsub ? "R2" : "R1";
    if (tinv) return "R7";
    if (tsub) return "R10";
    case (tfn)
      2'b00: return "R3";
      2'b01: return "R4";
      2'b10: return "R5";
      default: return "R6";
    endcase
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [W:0] r_c0, r_c1, r_i0, r_i1;
    void'($urandom(32'd20240611));
    a = '0; b = '0; arith = 1'b0; sub = 1'b0; fn = 2'b00; inv = 1'b0; cin = 1'b0;
    @(negedge clk);
    check("R3 idle inputs", '0);

    // Directed corner cases
    run("R11 full ripple", {W{1'b1}}, '0, 1'b1, 1'b0, 2'b00, 1'b0, 1'b1);
    check("R11 value", {1'b1, {W{1'b0}}});
    run("R1 max plus max", {W{1'b1}}, {W{1'b1}}, 1'b1, 1'b0, 2'b00, 1'b0, 1'b1);
    run("R2 equal sub", W'(5), W'(5), 1'b1, 1'b1, 2'b00, 1'b0, 1'b1);
    check("R2 equal gives zero, no borrow", {1'b1, {W{1'b0}}});
    run("R2 borrow", W'(3), W'(7), 1'b1, 1'b1, 2'b00, 1'b0, 1'b1);
    check("R2 borrow value", {1'b0, W'(3 - 7)});
    run("R7 all ones", W'(6), W'(9), 1'b0, 1'b0, 2'b00, 1'b1, 1'b0);
    check("R7 all ones value", {1'b0, {W{1'b1}}});
    run("R7 NAND", W'(12), W'(10), 1'b0, 1'b0, 2'b10, 1'b1, 1'b0);
    run("R7 NOR", W'(12), W'(10), 1'b0, 1'b0, 2'b11, 1'b1, 1'b0);
    run("R7 XNOR", W'(12), W'(10), 1'b0, 1'b0, 2'b01, 1'b1, 1'b0);
    run("R10 and-not", W'(12), W'(10), 1'b0, 1'b1, 2'b10, 1'b0, 1'b0);
    check("R10 value", {1'b0, W'(4)});

    // R8: carry-in ignored in logic mode, carry-out held low
    apply(W'(15), W'(15), 1'b0, 1'b0, 2'b10, 1'b0, 1'b0);
    r_c0 = {cout, y};
    apply(W'(15), W'(15), 1'b0, 1'b0, 2'b10, 1'b0, 1'b1);
    r_c1 = {cout, y};
    n_chk++;
    if (r_c0 !== r_c1 || r_c1 !== {1'b0, {W{1'b1}}}) begin
      n_bad++;
      $display("FAIL R8: got %h/%h, expected %h", r_c0, r_c1, {1'b0, {W{1'b1}}});
    end

    // R9: invert ignored in arithmetic mode
    apply(W'(9), W'(8), 1'b1, 1'b0, 2'b11, 1'b0, 1'b0);
    r_i0 = {cout, y};
    apply(W'(9), W'(8), 1'b1, 1'b0, 2'b11, 1'b1, 1'b0);
    r_i1 = {cout, y};
    n_chk++;
    if (r_i0 !== r_i1 || r_i1 !== (W+1)'(17)) begin
      n_bad++;
      $display("FAIL R9: got %h/%h, expected %h", r_i0, r_i1, (W+1)'(17));
    end

    // Constrained random
    for (int i = 0; i < 3000; i++) begin
      logic [W-1:0] ra, rb;
      logic rar, rsub, rinv, rcin;
      logic [1:0] rfn;
      ra = W'($urandom); rb = W'($urandom);
      rar = 1'($urandom); rsub = 1'($urandom); rinv = 1'($urandom);
      rcin = rsub ? 1'b1 : 1'($urandom);
      rfn = 2'($urandom);
      run(tag_of(rar, rsub, rfn, rinv), ra, rb, rar, rsub, rfn, rinv, rcin);
      if (!rar) begin
        n_chk++;
        if (cout !== 1'b0) begin
          n_bad++;
          $display("FAIL R8 random: got cout=%0b, expected 0", cout);
        end
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule